// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block converts a single PWM command into two gate-enable outputs for a synchronous buck power stage. One output enables the upper (high-side) switch and the other enables the lower (rectifier) switch. The two are never on together. The dead time between them is not a fixed count. It adapts to feedback bits from the power stage, and each feedback path has a counted fallback.

The block takes three comparator bits, all assumed to be already synchronized to the clock:

- a switch-node-high indication;
- a switch-node-below-threshold indication;
- a low-side-gate-discharged indication.

When the upper switch turns off, the lower switch is enabled by one of three paths:

- the switch node was seen high and has then dropped below its threshold;
- the switch node was never seen high, so a short fixed delay expires;
- the switch node stays high, so a longer timeout expires.

When the lower switch turns off, the upper switch waits for the lower gate to read as discharged, then waits a short fixed delay. An active-low disable input forces both outputs low immediately. After that input is released, and after reset, nothing is enabled until the next PWM edge.

All delays are counted in clock cycles. The limits are parameters: `FIX_DLY` (default 12), `TMO_DLY` (default 24) and `HS_DLY` (default 4). The defaults correspond to 120 ns, 240 ns and 40 ns at 100 MHz. `TMO_DLY` must exceed `FIX_DLY`.

Top module: `gate_seq`

## Requirements
- R1: In steady state, `hs_en_o` is high while `pwm_i` is high and `ls_en_o` is high while `pwm_i` is low, once the handover rules below have completed.
- R2: `hs_en_o` and `ls_en_o` are never high in the same cycle.
- R3: While `drv_ok_n_i` is low, both enables are low in that same cycle without waiting for a clock edge, whatever `pwm_i` and the comparator bits do.
- R4: After reset, and after `drv_ok_n_i` returns high, both enables stay low until the first clock edge that sees `pwm_i` differ from its value at the previous edge. Sequencing then resumes from that edge.
- R5: On a PWM falling edge, `hs_en_o` drops after the first clock edge that samples `pwm_i` low.
- R6: Comparator path. If `sw_hi_i` is sampled high at some edge after `hs_en_o` fell, then `ls_en_o` rises after the first later edge that samples `sw_lo_i` high.
- R7: Fixed path. If `sw_hi_i` was not sampled high, `ls_en_o` rises exactly `FIX_DLY` cycles after `hs_en_o` fell. `sw_lo_i` alone does not bring it earlier.
- R8: Timeout path. If the switch node was seen high but `sw_lo_i` never arrives, `ls_en_o` rises exactly `TMO_DLY` cycles after `hs_en_o` fell. The fixed path does not apply in this case.
- R9: On a PWM rising edge, `ls_en_o` drops after that edge. `hs_en_o` stays low while `lsg_lo_i` is low. It rises `HS_DLY` cycles after the first edge that samples `lsg_lo_i` high.
- R10: A PWM edge that arrives while a handover wait is running abandons that wait. The opposite handover then starts with both enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | PWM command; high requests the upper switch |
| drv_ok_n_i | input | 1 | Active-low disable; low forces both enables off |
| sw_lo_i | input | 1 | Switch node below its low threshold |
| sw_hi_i | input | 1 | Switch node seen high |
| lsg_lo_i | input | 1 | Lower gate discharged below its threshold |
| hs_en_o | output | 1 | Upper switch gate enable |
| ls_en_o | output | 1 | Lower switch gate enable |

## Verification
The bench builds the block with `FIX_DLY`=6, `TMO_DLY`=10 and `HS_DLY`=3. With these values, every edge of each window is reached in a handful of cycles. The gap between 6 and 10 makes the timeout path distinguishable from the fixed path: the bench checks the enable as still low in cycle 9 when the node was seen high. The small `HS_DLY` lets the bench hold the gate comparator low for longer than the delay itself, which shows that the counter does not start before discharge is reported.

// File: rtl/gs_pkg.sv
package gs_pkg;

    // Sequencer states: which switch owns the stage, or which handover runs
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // both off, waiting for a PWM edge
        ST_HS_ON = 3'd1,  // upper switch enabled
        ST_HL_WT = 3'd2,  // upper off, waiting to enable lower
        ST_LS_ON = 3'd3,  // lower switch enabled
        ST_LH_GT = 3'd4,  // lower off, waiting for its gate to discharge
        ST_LH_DL = 3'd5   // lower gate discharged, counting guard delay
    } gs_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } gs_edge_t;

    // Width needed to hold values 0..max_val
    function automatic int gs_cnt_w(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

endpackage

// File: rtl/gs_edge_det.sv
module gs_edge_det
    import gs_pkg::*;
(
    input  logic     clk,
    input  logic     pwm_i,
    output gs_edge_t edge_o
);
    logic pwm_q;

    // Tracks PWM even in reset, so no edge is reported on reset release
    always_ff @(posedge clk) begin
        pwm_q <= pwm_i;
    end

    always_comb begin
        edge_o.rise = pwm_i & ~pwm_q;
        edge_o.fall = ~pwm_i & pwm_q;
    end
endmodule

// File: rtl/gs_dead_timer.sv
module gs_dead_timer #(
    parameter int MAX_CNT = 24,
    localparam int W = gs_pkg::gs_cnt_w(MAX_CNT)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = W'(MAX_CNT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/gs_fsm.sv
module gs_fsm
    import gs_pkg::*;
#(
    parameter int FIX_DLY = 12,
    parameter int TMO_DLY = 24,
    parameter int HS_DLY  = 4,
    localparam int W = gs_cnt_w(TMO_DLY > HS_DLY ? TMO_DLY : HS_DLY)
) (
    input  logic         clk,
    input  logic         rst,
    input  gs_edge_t     edge_i,
    input  logic         drv_ok_n_i,
    input  logic         sw_lo_i,
    input  logic         sw_hi_i,
    input  logic         lsg_lo_i,
    input  logic [W-1:0] tmr_i,
    output logic         tmr_clr_o,
    output logic         hs_raw_o,
    output logic         ls_raw_o
);
    localparam logic [W-1:0] FIX_M1 = W'(FIX_DLY - 1);
    localparam logic [W-1:0] TMO_M1 = W'(TMO_DLY - 1);
    localparam logic [W-1:0] HS_M1  = W'(HS_DLY - 1);

    gs_state_e st_q, st_d;
    logic      seen_hi_q;
    logic      ls_go;

    // Any of the three low-side release paths
    always_comb begin
        ls_go = (seen_hi_q && sw_lo_i)
             || (!seen_hi_q && tmr_i == FIX_M1)
             || (tmr_i == TMO_M1);
    end

    always_comb begin
        st_d = st_q;
        if (!drv_ok_n_i) begin
            st_d = ST_IDLE;
        end else if (edge_i.fall) begin
            st_d = ST_HL_WT;
        end else if (edge_i.rise) begin
            st_d = ST_LH_GT;
        end else begin
            unique case (st_q)
                ST_HL_WT: if (ls_go)             st_d = ST_LS_ON;
                ST_LH_GT: if (lsg_lo_i)          st_d = ST_LH_DL;
                ST_LH_DL: if (tmr_i == HS_M1)    st_d = ST_HS_ON;
                default:  st_d = st_q;
            endcase
        end
    end

    assign tmr_clr_o = (st_d != st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            seen_hi_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_d == ST_HL_WT && st_q != ST_HL_WT) begin
                seen_hi_q <= 1'b0;
            end else if (st_q == ST_HL_WT && sw_hi_i) begin
                seen_hi_q <= 1'b1;
            end
        end
    end

    assign hs_raw_o = (st_q == ST_HS_ON);
    assign ls_raw_o = (st_q == ST_LS_ON);

    // R6 R7 R8
    ls_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_raw_o) |-> ($past(seen_hi_q && sw_lo_i) || $past(tmr_i) == FIX_M1
                             || $past(tmr_i) == TMO_M1));

    // R9
    hs_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_raw_o) |-> ($past(tmr_i) == HS_M1 && !$past(ls_raw_o)));

    // R3
    dis_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !drv_ok_n_i |=> (st_q == ST_IDLE));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !edge_i.rise && !edge_i.fall) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/gate_seq.sv
module gate_seq #(
    parameter int FIX_DLY = 12,
    parameter int TMO_DLY = 24,
    parameter int HS_DLY  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_i,
    input  logic drv_ok_n_i,
    input  logic sw_lo_i,
    input  logic sw_hi_i,
    input  logic lsg_lo_i,
    output logic hs_en_o,
    output logic ls_en_o
);
    import gs_pkg::*;

    localparam int TMAX = (TMO_DLY > HS_DLY) ? TMO_DLY : HS_DLY;
    localparam int W    = gs_cnt_w(TMAX);

    gs_edge_t     pwm_edge;
    logic [W-1:0] tmr;
    logic         tmr_clr;
    logic         hs_raw, ls_raw;

    gs_edge_det u_edge (
        .clk    (clk),
        .pwm_i  (pwm_i),
        .edge_o (pwm_edge)
    );

    gs_dead_timer #(.MAX_CNT(TMAX)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tmr_clr),
        .cnt_o (tmr)
    );

    gs_fsm #(.FIX_DLY(FIX_DLY), .TMO_DLY(TMO_DLY), .HS_DLY(HS_DLY)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (pwm_edge),
        .drv_ok_n_i (drv_ok_n_i),
        .sw_lo_i    (sw_lo_i),
        .sw_hi_i    (sw_hi_i),
        .lsg_lo_i   (lsg_lo_i),
        .tmr_i      (tmr),
        .tmr_clr_o  (tmr_clr),
        .hs_raw_o   (hs_raw),
        .ls_raw_o   (ls_raw)
    );

    // Disable acts without waiting for a clock edge
    assign hs_en_o = hs_raw & drv_ok_n_i;
    assign ls_en_o = ls_raw & drv_ok_n_i;

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(hs_en_o && ls_en_o));
endmodule

// File: tb/gate_seq_tb.sv
module gate_seq_tb;
    localparam int FIX = 6;
    localparam int TMO = 10;
    localparam int HSD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm = 1'b0, ok_n = 1'b1, sw_lo = 1'b0, sw_hi = 1'b0, lsg_lo = 1'b0;
    logic hs, ls;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gate_seq #(.FIX_DLY(FIX), .TMO_DLY(TMO), .HS_DLY(HSD)) u_dut (
        .clk(clk), .rst(rst), .pwm_i(pwm), .drv_ok_n_i(ok_n),
        .sw_lo_i(sw_lo), .sw_hi_i(sw_hi), .lsg_lo_i(lsg_lo),
        .hs_en_o(hs), .ls_en_o(ls)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // R2: overlap watch at every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            n_chk++;
            if (hs === 1'b1 && ls === 1'b1) begin
                n_bad++;
                $display("FAIL R2 overlap: got hs=%b ls=%b expected not both 1", hs, ls);
            end
        end
    end

    // Bring the stage to upper-on from a low PWM
    task automatic go_hs();
        lsg_lo = 1'b1;
        pwm = 1'b1;
        repeat (HSD + 2) tick();
        check("R1", "hs after rise", hs, 1'b1);
        lsg_lo = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; pwm = 1'b0;
        repeat (3) tick();
        check("R4", "hs in reset", hs, 1'b0);
        check("R4", "ls in reset", ls, 1'b0);
        pwm = 1'b1;
        tick();
        rst = 1'b0;
        repeat (5) tick();
        check("R4", "hs idle after reset", hs, 1'b0);
        check("R4", "ls idle after reset", ls, 1'b0);
    endtask

    task automatic t_fixed();
        pwm = 1'b0; sw_lo = 1'b1; sw_hi = 1'b0;
        tick();
        check("R5", "hs after fall", hs, 1'b0);
        repeat (FIX - 1) tick();
        check("R7", "ls before fixed delay", ls, 1'b0);
        tick();
        check("R7", "ls at fixed delay", ls, 1'b1);
        check("R1", "ls with pwm low", ls, 1'b1);
        sw_lo = 1'b0;
    endtask

    task automatic t_rise();
        pwm = 1'b1; lsg_lo = 1'b0;
        tick();
        check("R9", "ls after rise", ls, 1'b0);
        repeat (5) tick();
        check("R9", "hs while gate high", hs, 1'b0);
        lsg_lo = 1'b1;
        tick();
        check("R9", "hs at gate sample", hs, 1'b0);
        repeat (HSD - 1) tick();
        check("R9", "hs before guard", hs, 1'b0);
        tick();
        check("R9", "hs after guard", hs, 1'b1);
        lsg_lo = 1'b0;
    endtask

    task automatic t_cmp();
        pwm = 1'b0;
        tick();
        check("R5", "hs off", hs, 1'b0);
        sw_hi = 1'b1;
        tick();
        check("R6", "ls while node high", ls, 1'b0);
        sw_hi = 1'b0; sw_lo = 1'b1;
        tick();
        check("R6", "ls after node low", ls, 1'b1);
        sw_lo = 1'b0;
    endtask

    task automatic t_timeout();
        go_hs();
        pwm = 1'b0;
        tick();
        sw_hi = 1'b1;
        tick();
        sw_hi = 1'b0;
        repeat (TMO - 2) tick();
        check("R8", "ls before timeout", ls, 1'b0);
        tick();
        check("R8", "ls at timeout", ls, 1'b1);
    endtask

    task automatic t_reverse();
        pwm = 1'b1; lsg_lo = 1'b0;
        tick();
        pwm = 1'b0;
        tick();
        check("R10", "hs after reversal", hs, 1'b0);
        check("R10", "ls after reversal", ls, 1'b0);
        pwm = 1'b1;
        tick();
        repeat (FIX + 2) tick();
        check("R10", "ls wait abandoned", ls, 1'b0);
        check("R10", "hs held for gate", hs, 1'b0);
        lsg_lo = 1'b1;
        repeat (HSD + 1) tick();
        check("R10", "hs after new handover", hs, 1'b1);
        lsg_lo = 1'b0;
    endtask

    task automatic t_disable();
        ok_n = 1'b0;
        #1;
        check("R3", "hs at once", hs, 1'b0);
        check("R3", "ls at once", ls, 1'b0);
        pwm = 1'b0;
        repeat (FIX + 2) tick();
        check("R3", "ls with pwm low", ls, 1'b0);
        pwm = 1'b1; lsg_lo = 1'b1;
        repeat (HSD + 3) tick();
        check("R3", "hs with pwm high", hs, 1'b0);
        lsg_lo = 1'b0; pwm = 1'b0;
        tick();
        ok_n = 1'b1;
        repeat (FIX + 3) tick();
        check("R4", "hs after release", hs, 1'b0);
        check("R4", "ls after release", ls, 1'b0);
        go_hs();
        check("R4", "resume on edge", hs, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fixed();
                t_rise();
                t_cmp();
                t_timeout();
                t_reverse();
                t_disable();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got hang expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule